// File: doc/BRIEF.md
# D-PHY Lane Timing Parameter Generator

This block turns a per-lane serial bit rate, given as an integer number of MHz, into the set of timing counts that a MIPI D-PHY transmitter needs for its data lanes, for bus turnaround and for its clock lane. Each count is an 8-bit value. The block places the counts into four 32-bit configuration words, ready for a configuration path to copy into the PHY.

A request is made by pulsing `start` with the rate applied. The block then runs as a small sequential calculator. Four bit-serial dividers, each by the same fixed constant, work in parallel and produce one quotient bit per cycle. A final cycle derives every field, applies any per-field replacement that was requested, and registers the four words. `done` then pulses for one cycle.

Per-field replacement is useful when a board needs hand-tuned values. Each field has an enable bit and an 8-bit value. A set enable bit replaces that field in the packed output. Fields that are derived from it still follow the computed value.

Top module: `dphy_timing_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first completion, `busy` and `done` are 0 and all four words read zero.
- R2: With R as the accepted rate, the LPX count L = floor(60·R/8000)+1 appears in bits 7:0 of `word0`.
- R3: `word0` holds the HS-prepare count P = floor((80·R+4000)/8000) in bits 15:8, the HS-zero count floor((170·R+10000)/8000)+1−P in bits 23:16, and the HS-trail count P+1 in bits 31:24.
- R4: `word1` holds 4·L−2 (turnaround go) in bits 7:0, L+2 (turnaround sure) in bits 15:8, 4·L (turnaround get) in bits 23:16 and 2·L+1 (HS exit) in bits 31:24.
- R5: With C = floor(70·R/8000), `word2` holds 0 in bits 7:0, the HS-sync count 1 in bits 15:8, 4·C (clock zero) in bits 23:16 and C (clock trail) in bits 31:24.
- R6: `word3` holds C (clock prepare) in bits 7:0, C+8 (clock post) in bits 15:8, 2·C (clock exit) in bits 23:16 and 0 in bits 31:24. All field arithmetic is modulo 256.
- R7: If bit i of `ovr_mask` is set when a request is accepted, field i takes the value `ovr_value[8i+7:8i]`. The index order is 0 LPX, 1 HS-prepare, 2 HS-zero, 3 HS-trail, 4 turnaround go, 5 turnaround sure, 6 turnaround get, 7 HS exit, 8 HS-sync, 9 clock zero, 10 clock trail, 11 clock prepare, 12 clock post, 13 clock exit. Fields derived from a replaced field still use the computed value.
- R8: A `start` seen at a rising edge while idle is accepted. With the default 12-bit rate, `busy` is high for the next 8 cycles. `done` is high for exactly one cycle, directly after the 8th rising edge following acceptance, and `busy` is low while `done` is high. A new request may be accepted in the cycle in which `done` is high.
- R9: A `start` that arrives while `busy` is high is ignored. The result, its timing and the following idle state are those of the request that is running.
- R10: `rate_mhz`, `ovr_mask` and `ovr_value` are sampled only when a request is accepted. The four words change only at the edge at which `done` rises and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a computation |
| rate_mhz | input | RATE_W (12) | Per-lane bit rate in MHz |
| ovr_mask | input | 14 | Per-field replacement enables |
| ovr_value | input | 112 | Replacement values, 8 bits per field |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| word0 | output | 32 | LPX and HS-prepare/zero/trail |
| word1 | output | 32 | Turnaround go/sure/get and HS exit |
| word2 | output | 32 | HS-sync, clock zero, clock trail |
| word3 | output | 32 | Clock prepare, post and exit |

## Verification
A divider whose remainder or quotient bit goes wrong shows up as a wrong byte in the words at the single `done` edge of that request. Because the fields share quotients, one bad quotient changes several lanes together. For example, a bad LPX moves four bytes of `word1`. A bad step counter or state register moves the `done` pulse off its eighth edge, or lets a second `start` restart the run. That mismatch appears on `busy` within one cycle. The bench compares `busy`, `done` and every byte against a behavioural model on every clock, so any departure is caught in the cycle it becomes visible.

// File: rtl/dphy_tg_pkg.sv
package dphy_tg_pkg;

   localparam int NUM_FIELDS = 14;
   localparam int NUM_DIV    = 4;
   localparam int NUM_WORDS  = 4;
   localparam int DIVISOR    = 8000;

   // field index order (also the override bus order)
   localparam int F_LPX      = 0;
   localparam int F_HS_PREP  = 1;
   localparam int F_HS_ZERO  = 2;
   localparam int F_HS_TRAIL = 3;
   localparam int F_TA_GO    = 4;
   localparam int F_TA_SURE  = 5;
   localparam int F_TA_GET   = 6;
   localparam int F_HS_EXIT  = 7;
   localparam int F_HS_SYNC  = 8;
   localparam int F_CK_ZERO  = 9;
   localparam int F_CK_TRAIL = 10;
   localparam int F_CK_PREP  = 11;
   localparam int F_CK_POST  = 12;
   localparam int F_CK_EXIT  = 13;

   typedef logic [7:0] fld_t;
   typedef fld_t [NUM_FIELDS-1:0] fld_vec_t;
   typedef logic [NUM_WORDS-1:0][31:0] word_vec_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_PACK = 2'd2
   } seq_state_e;

   // divider d computes floor((div_mult(d)*R + div_add(d)) / DIVISOR)
   function automatic int div_mult(input int d);
      case (d)
         0:       return 60;
         1:       return 80;
         2:       return 170;
         default: return 70;
      endcase
   endfunction

   function automatic int div_add(input int d);
      case (d)
         1:       return 4000;
         2:       return 10000;
         default: return 0;
      endcase
   endfunction

   // which output word a field lands in; the lane layout is fixed by the PHY
   function automatic int fld_word(input int f);
      if (f <= F_HS_TRAIL)      return 0;
      else if (f <= F_HS_EXIT)  return 1;
      else if (f <= F_CK_TRAIL) return 2;
      else                      return 3;
   endfunction

   function automatic int fld_lane(input int f);
      case (fld_word(f))
         0:       return f;
         1:       return f - F_TA_GO;
         2:       return f - F_HS_SYNC + 1;
         default: return f - F_CK_PREP;
      endcase
   endfunction

endpackage

// File: rtl/dphy_tg_cdiv.sv
module dphy_tg_cdiv #(
   parameter int NUM_W   = 20,
   parameter int QW      = 7,
   parameter int DIVISOR = 8000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [NUM_W-1:0]      numer,
   input  logic                  step_en,
   input  logic [$clog2(QW)-1:0] bit_idx,
   output logic [QW-1:0]         quot
);
   localparam int EXT_W = NUM_W + QW;
   localparam int IDX_W = $clog2(QW);

   logic [EXT_W-1:0] rem_q;
   logic [EXT_W-1:0] shifted;
   logic [QW-1:0]    quot_q;
   logic             take;

   if (DIVISOR < 2) begin : g_bad_div
      $error("dphy_tg_cdiv: divisor must be at least 2");
   end

   assign shifted = EXT_W'(DIVISOR) << bit_idx;
   assign take    = (rem_q >= shifted);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quot_q <= '0;
      end else if (load) begin
         rem_q  <= EXT_W'(numer);
         quot_q <= '0;
      end else if (step_en && take) begin
         rem_q           <= rem_q - shifted;
         quot_q[bit_idx] <= 1'b1;
      end
   end

   assign quot = quot_q;

   // R3: once the last quotient bit is resolved the remainder is below the divisor
   a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      $past(step_en && (bit_idx == IDX_W'(0))) |-> (rem_q < EXT_W'(DIVISOR)));

endmodule

// File: rtl/dphy_tg_fields.sv
module dphy_tg_fields
   import dphy_tg_pkg::*;
#(
   parameter int QW     = 7,
   parameter bit OVR_EN = 1'b1
) (
   input  logic [QW-1:0]         quot [NUM_DIV],
   input  logic [NUM_FIELDS-1:0] ovr_mask,
   input  fld_vec_t              ovr_val,
   output fld_vec_t              fld
);
   fld_t     q_lpx, q_prep, q_zero, q_clk;
   fld_t     lpx;
   fld_vec_t calc;

   assign q_lpx  = fld_t'(quot[0]);
   assign q_prep = fld_t'(quot[1]);
   assign q_zero = fld_t'(quot[2]);
   assign q_clk  = fld_t'(quot[3]);
   assign lpx    = q_lpx + 8'd1;

   always_comb begin
      calc             = '0;
      calc[F_LPX]      = lpx;
      calc[F_HS_PREP]  = q_prep;
      calc[F_HS_ZERO]  = q_zero + 8'd1 - q_prep;
      calc[F_HS_TRAIL] = q_prep + 8'd1;
      calc[F_TA_GO]    = (lpx << 2) - 8'd2;
      calc[F_TA_SURE]  = lpx + 8'd2;
      calc[F_TA_GET]   = lpx << 2;
      calc[F_HS_EXIT]  = (lpx << 1) + 8'd1;
      calc[F_HS_SYNC]  = 8'd1;
      calc[F_CK_ZERO]  = q_clk << 2;
      calc[F_CK_TRAIL] = q_clk;
      calc[F_CK_PREP]  = q_clk;
      calc[F_CK_POST]  = q_clk + 8'd8;
      calc[F_CK_EXIT]  = q_clk << 1;
   end

   if (OVR_EN) begin : g_ovr
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
         assign fld[i] = ovr_mask[i] ? ovr_val[i] : calc[i];
      end
   end else begin : g_no_ovr
      logic unused_ovr;
      assign unused_ovr = ^{ovr_mask, ovr_val};
      assign fld        = calc;
   end

endmodule

// File: rtl/dphy_tg_pack.sv
module dphy_tg_pack
   import dphy_tg_pkg::*;
(
   input  fld_vec_t  fld,
   output word_vec_t words
);
   always_comb begin
      words = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         words[fld_word(f)][fld_lane(f)*8 +: 8] = fld[f];
      end
   end
endmodule

// File: rtl/dphy_timing_gen.sv
module dphy_timing_gen
   import dphy_tg_pkg::*;
#(
   parameter int RATE_W = 12,
   parameter bit OVR_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [RATE_W-1:0]       rate_mhz,
   input  logic [NUM_FIELDS-1:0]   ovr_mask,
   input  logic [NUM_FIELDS*8-1:0] ovr_value,
   output logic                    busy,
   output logic                    done,
   output logic [31:0]             word0,
   output logic [31:0]             word1,
   output logic [31:0]             word2,
   output logic [31:0]             word3
);
   localparam int NUM_W = RATE_W + 8;
   localparam int QMAX  = (170 * (2**RATE_W - 1) + 10000) / DIVISOR;
   localparam int QW    = $clog2(QMAX + 1);
   localparam int IDX_W = $clog2(QW);

   if (RATE_W < 7 || RATE_W > 16) begin : g_bad_rate_w
      $error("dphy_timing_gen: RATE_W must lie in 7..16");
   end

   seq_state_e                state_q;
   logic [IDX_W-1:0]          bit_idx_q;
   logic [NUM_FIELDS-1:0]     mask_q;
   fld_vec_t                  val_q;
   word_vec_t                 words_q;
   logic                      done_q;
   logic                      accept;
   logic                      step_en;
   logic [QW-1:0]             quot [NUM_DIV];
   fld_vec_t                  fld;
   word_vec_t                 packed_w;

   assign accept  = (state_q == ST_IDLE) && start;
   assign step_en = (state_q == ST_DIV);

   for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
      logic [NUM_W-1:0] numer;
      assign numer = NUM_W'(div_mult(d)) * NUM_W'(rate_mhz) + NUM_W'(div_add(d));

      dphy_tg_cdiv #(
         .NUM_W  (NUM_W),
         .QW     (QW),
         .DIVISOR(DIVISOR)
      ) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (accept),
         .numer  (numer),
         .step_en(step_en),
         .bit_idx(bit_idx_q),
         .quot   (quot[d])
      );
   end

   dphy_tg_fields #(
      .QW    (QW),
      .OVR_EN(OVR_EN)
   ) u_fields (
      .quot    (quot),
      .ovr_mask(mask_q),
      .ovr_val (val_q),
      .fld     (fld)
   );

   dphy_tg_pack u_pack (
      .fld  (fld),
      .words(packed_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_idx_q <= '0;
         mask_q    <= '0;
         val_q     <= '0;
         words_q   <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mask_q    <= ovr_mask;
                  val_q     <= ovr_value;
                  bit_idx_q <= IDX_W'(QW - 1);
                  state_q   <= ST_DIV;
               end
            end
            ST_DIV: begin
               if (bit_idx_q == IDX_W'(0)) begin
                  state_q <= ST_PACK;
               end else begin
                  bit_idx_q <= bit_idx_q - IDX_W'(1);
               end
            end
            ST_PACK: begin
               words_q <= packed_w;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;
   assign word0 = words_q[0];
   assign word1 = words_q[1];
   assign word2 = words_q[2];
   assign word3 = words_q[3];

   // R8: completion is a single-cycle pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: the block is idle while reporting completion
   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9: a running computation walks its bit index down without restarting
   a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DIV && bit_idx_q != IDX_W'(0)) |=>
         (state_q == ST_DIV && bit_idx_q == $past(bit_idx_q) - IDX_W'(1)));

   // R10: the words only move together with the completion pulse
   a_r10_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({word0, word1, word2, word3}));

   // R4: turnaround get is four LPX periods when neither field is replaced
   a_r4_ta_get_vs_lpx: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mask_q[F_TA_GET] && !mask_q[F_LPX]) |->
         (word1[23:16] == {word0[5:0], 2'b00}));

endmodule

// File: tb/dphy_timing_gen_test.sv
`timescale 1ns/1ps
module dphy_timing_gen_test;
   import dphy_tg_pkg::*;

   localparam int RW  = 12;
   localparam int LAT = 8;   // R8: edges from acceptance to done

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    start = 1'b0;
   logic [RW-1:0]           rate_mhz = '0;
   logic [NUM_FIELDS-1:0]   ovr_mask = '0;
   logic [NUM_FIELDS*8-1:0] ovr_value = '0;
   logic                    busy, done;
   logic [31:0]             word0, word1, word2, word3;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 1'b0;
   string tag      = "R1 reset";

   always #2.5 clk = ~clk;

   dphy_timing_gen #(.RATE_W(RW), .OVR_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_mhz(rate_mhz),
      .ovr_mask(ovr_mask), .ovr_value(ovr_value), .busy(busy), .done(done),
      .word0(word0), .word1(word1), .word2(word2), .word3(word3)
   );

   function automatic logic [127:0] ref_words(input int r, input logic [13:0] m,
                                              input logic [111:0] v);
      int f [14];
      int l, p, c;
      logic [127:0] w;
      l = 60 * r / 8000 + 1;
      p = (80 * r + 4000) / 8000;
      c = 70 * r / 8000;
      f[0] = l;  f[1] = p;  f[2] = (170 * r + 10000) / 8000 + 1 - p;  f[3] = p + 1;
      f[4] = 4 * l - 2;  f[5] = l + 2;  f[6] = 4 * l;  f[7] = 2 * l + 1;
      f[8] = 1;  f[9] = 4 * c;  f[10] = c;
      f[11] = c; f[12] = c + 8; f[13] = 2 * c;
      for (int i = 0; i < 14; i++) if (m[i]) f[i] = int'(v[8*i +: 8]);
      w = '0;
      w[7:0]     = 8'(f[0]);  w[15:8]    = 8'(f[1]);  w[23:16]   = 8'(f[2]);  w[31:24]   = 8'(f[3]);
      w[39:32]   = 8'(f[4]);  w[47:40]   = 8'(f[5]);  w[55:48]   = 8'(f[6]);  w[63:56]   = 8'(f[7]);
      w[79:72]   = 8'(f[8]);  w[87:80]   = 8'(f[9]);  w[95:88]   = 8'(f[10]);
      w[103:96]  = 8'(f[11]); w[111:104] = 8'(f[12]); w[119:112] = 8'(f[13]);
      return w;
   endfunction

   // behavioural reference model, advanced on every rising edge
   int           m_cnt = 0;
   logic         m_done = 1'b0;
   logic [127:0] m_w = '0;
   int           m_rate = 0;
   logic [13:0]  m_mask = '0;
   logic [111:0] m_val = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 1'b0; m_w = '0;
      end else begin
         m_done = 1'b0;
         if (m_cnt == 0) begin
            if (start) begin
               m_rate = int'(rate_mhz); m_mask = ovr_mask; m_val = ovr_value;
               m_cnt = LAT;
            end
         end else begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_done = 1'b1;
               m_w = ref_words(m_rate, m_mask, m_val);
            end
         end
      end
   end

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] actual %h expected %h at %0t", what, tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         check("R8 busy", 32'(busy), 32'(m_cnt != 0));
         check("R8 done", 32'(done), 32'(m_done));
         check("R2 lpx w0[7:0]",    32'(word0[7:0]),   32'(m_w[7:0]));
         check("R3 hs w0[31:8]",    32'(word0[31:8]),  32'(m_w[31:8]));
         check("R4 ta/exit w1",     word1,             m_w[63:32]);
         check("R5 sync/clk w2",    word2,             m_w[95:64]);
         check("R6 clk w3",         word3,             m_w[127:96]);
      end
   end

   task automatic report;
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic go(input int r, input logic [13:0] m, input logic [111:0] v);
      @(negedge clk);
      start = 1'b1; rate_mhz = RW'(r); ovr_mask = m; ovr_value = v;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT + 1) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog [%s] actual %h expected %h", tag, 32'd1, 32'd0);
      report();
   end

   initial begin
      // R1: reset state, also held after reset until the first request
      repeat (4) @(negedge clk);
      check("R1 reset busy", 32'(busy), 32'd0);
      check("R1 reset word0", word0, 32'd0);
      check("R1 reset word3", word3, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle word2", word2, 32'd0);

      // R2 R3 R4 R5 R6: formula boundaries and typical rates
      tag = "R2-formula";
      go(0, '0, '0);
      go(49, '0, '0);
      go(50, '0, '0);
      go(133, '0, '0);
      go(134, '0, '0);
      go(800, '0, '0);
      go(1000, '0, '0);
      go(1500, '0, '0);
      go(2500, '0, '0);
      go(4095, '0, '0);

      // R7: field replacement; derived fields keep computed values
      tag = "R7 override";
      go(1000, 14'b00_0000_0000_0001, {104'd0, 8'hA5});
      go(1200, 14'b10_1001_0000_0110, {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
                                       8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE});
      go(2000, 14'h3FFF, {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                          8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E});

      // R9: start while busy is ignored; R10: inputs changing mid-run
      tag = "R9 R10 busy-start";
      @(negedge clk);
      start = 1'b1; rate_mhz = 12'd900; ovr_mask = '0;
      @(negedge clk);
      start = 1'b0; rate_mhz = 12'd3000; ovr_mask = 14'h3FFF; ovr_value = '1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; rate_mhz = 12'd77;
      repeat (LAT + 4) @(negedge clk);

      // R8: new request accepted while done is high
      tag = "R8 back-to-back";
      ovr_mask = '0;
      @(negedge clk);
      start = 1'b1; rate_mhz = 12'd600;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT) @(negedge clk);
      start = 1'b1; rate_mhz = 12'd1800;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT + 3) @(negedge clk);

      // R10: words hold across a long idle stretch
      tag = "R10 hold";
      repeat (20) @(negedge clk);

      report();
   end

endmodule